// File: doc/BRIEF.md
# Pointer-Indexed 32-Bit Store Unit

This block carries out one store instruction. It has four 32-bit pointer registers and one 16-bit index register. A two-byte opcode arrives on a byte stream with a valid/ready handshake. The second byte names a source pointer and a base pointer. The block adds the zero-extended index register to the base pointer to form an effective address. It then writes the source pointer to memory as four bytes, least significant byte first, at four rising addresses.

The upper half of the base pointer decides the kind of address. If those 16 bits are all ones, the address is logical: a translate flag goes out with every write, and the address keeps its low 16 bits. Any other base gives a physical address, trimmed to 20 or 24 bits by a configuration input. The block translates nothing itself.

A done pulse reproduces the instruction's cycle count. That count is fixed in one timing mode. In the other mode it depends on the bus width and on the alignment of the effective address. The pointer and index registers are loaded through a simple write port.

Top module: `ptr_store_unit`

## Requirements
- R1: A store starts only after byte 0x6D is accepted and is directly followed by an accepted byte whose bits 3:0 are 0xB. Any other first byte is dropped, and so is a non-matching second byte; the decoder then waits for a fresh 0x6D. A dropped byte causes no write, and busy_o stays low.
- R2: Bits 7:6 of the second byte pick the source pointer and bits 5:4 pick the base pointer. Both use the encoding 0=ptr0, 1=ptr1, 2=ptr2, 3=ptr3.
- R3: The effective address is the base pointer plus the index register zero-extended to 32 bits. The sum is taken modulo 2^32.
- R4: Exactly four writes are issued. Write k (k=0..3) carries bits 8k+7:8k of the source pointer, at effective address + k.
- R5: When base bits 31:16 are all ones, mem_xlat_o is high with every write. The address is then bits 15:0 of (effective address + k), zero-extended.
- R6: For any other base, mem_xlat_o is low. The address keeps bits 19:0 of (effective address + k) when cfg_addr24_i=0 and bits 23:0 when it is 1.
- R7: done_o is a one-cycle pulse. Number the cycle that accepts the second byte as cycle 2; with immediate memory acknowledgement, done_o comes in cycle N. N is 18 when cfg_tmode_i=0. When cfg_tmode_i=1, N is 17 if cfg_bus16_i=1 and the effective address is even, and 19 otherwise. Memory stalls delay done_o to no earlier than the cycle after the last write is acknowledged.
- R8: Each mem_we_o strobe lasts one cycle. The next write issues only in the cycle after a cycle in which mem_ready_i is seen high following the strobe.
- R9: busy_o is high from the cycle after the second byte through the done_o cycle, and low after that. op_ready_o is high only while busy_o is low.
- R10: Register write port: rf_sel_i 0..3 loads ptr0..ptr3 and 4 loads the index register from rf_wdata_i bits 15:0. Select codes 5..7 change nothing.
- R11: Reset clears all registers, aborts any store in progress, and holds mem_we_o, busy_o and done_o low with op_ready_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rf_we_i | input | 1 | Register write enable |
| rf_sel_i | input | 3 | Register select (0..3 pointers, 4 index) |
| rf_wdata_i | input | 32 | Register write data |
| op_valid_i | input | 1 | Opcode byte valid |
| op_byte_i | input | 8 | Opcode byte |
| op_ready_o | output | 1 | Opcode byte accepted when high with valid |
| cfg_tmode_i | input | 1 | Timing mode: 0 fixed, 1 bus dependent |
| cfg_bus16_i | input | 1 | 16-bit memory bus in timing mode 1 |
| cfg_addr24_i | input | 1 | Physical address width: 0 20 bits, 1 24 bits |
| mem_we_o | output | 1 | Byte write strobe |
| mem_addr_o | output | 32 | Write address |
| mem_data_o | output | 8 | Write data byte |
| mem_xlat_o | output | 1 | Address is logical and must be translated |
| mem_ready_i | input | 1 | Memory acknowledge |
| busy_o | output | 1 | Store in progress |
| done_o | output | 1 | Store complete pulse |

## Verification
The bench aims at addresses that wrap.
- A base of 0xFFFFFFF0 plus an index can carry past bit 31. A design that kept the carry, or that tested the upper half of the sum rather than of the base, would turn a logical store into a physical one.
- Byte offsets that cross the 16-bit, 20-bit and 24-bit boundaries catch masks applied to the base alone or applied at the wrong width.

It runs every cycle-count variant, including an odd effective address on a 16-bit bus. A wrong alignment test would move the done pulse by two cycles.

A long memory stall checks that the second write waits for the acknowledge and that done_o follows the last acknowledge rather than the timer. Near-miss opcodes and a reset in mid-store must leave memory untouched.

// File: rtl/ptr_store_pkg.sv
package ptr_store_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WR, SQ_ACK, SQ_HOLD} seq_state_e;
  typedef enum logic {DC_IDLE, DC_PFX} dec_state_e;
endpackage

// File: rtl/ptr_store_regfile.sv
module ptr_store_regfile #(
  parameter int PTR_W = 32,
  parameter int IDX_W = 16,
  parameter int NPTR  = 4,
  parameter int RS_W  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [RS_W-1:0]            sel_i,
  input  logic [PTR_W-1:0]           wdata_i,
  output logic [NPTR-1:0][PTR_W-1:0] ptr_o,
  output logic [IDX_W-1:0]           idx_o
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            ptr_o[g] <= '0;
      else if (we_i && sel_i == RS_W'(g))     ptr_o[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              idx_o <= '0;
    else if (we_i && sel_i == RS_W'(NPTR))    idx_o <= wdata_i[IDX_W-1:0];
  end
endmodule

// File: rtl/ptr_store_decode.sv
module ptr_store_decode
  import ptr_store_pkg::*;
#(
  parameter logic [7:0] PREFIX  = 8'h6D,
  parameter logic [3:0] SUB_NIB = 4'hB
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       ready_i,
  input  logic [7:0] byte_i,
  output logic       launch_o
);
  dec_state_e st_q;
  logic       accept;

  assign accept   = valid_i && ready_i;
  assign launch_o = (st_q == DC_PFX) && accept && (byte_i[3:0] == SUB_NIB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= DC_IDLE;
    else if (accept) begin
      // any byte after the prefix ends the pair, matching or not
      if (st_q == DC_PFX)          st_q <= DC_IDLE;
      else if (byte_i == PREFIX)   st_q <= DC_PFX;
    end
  end
endmodule

// File: rtl/ptr_store_agen.sv
module ptr_store_agen #(
  parameter int PTR_W    = 32,
  parameter int IDX_W    = 16,
  parameter int LOG_W    = 16,
  parameter int PHYS_NW  = 20,
  parameter int PHYS_WW  = 24,
  parameter int BI_W     = 2,
  parameter int TMR_W    = 5,
  parameter int CYC_FIX  = 18,
  parameter int CYC_SLOW = 19,
  parameter int CYC_FAST = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [PTR_W-1:0] base_i,
  input  logic [PTR_W-1:0] src_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             tmode_i,
  input  logic             bus16_i,
  input  logic             addr24_i,
  input  logic [BI_W-1:0]  byte_idx_i,
  output logic [TMR_W-1:0] cycles_o,
  output logic [PTR_W-1:0] addr_o,
  output logic [7:0]       data_o,
  output logic             logical_o
);
  localparam int HI_W = PTR_W - LOG_W;
  localparam logic [PTR_W-1:0] NMASK = {{(PTR_W-PHYS_NW){1'b0}}, {PHYS_NW{1'b1}}};
  localparam logic [PTR_W-1:0] WMASK = {{(PTR_W-PHYS_WW){1'b0}}, {PHYS_WW{1'b1}}};

  logic [PTR_W-1:0] ea_c, ea_q, src_q, a_k;
  logic             log_q, a24_q;

  assign ea_c = base_i + {{(PTR_W-IDX_W){1'b0}}, idx_i};

  always_comb begin
    if (!tmode_i)                 cycles_o = TMR_W'(CYC_FIX);
    else if (bus16_i && !ea_c[0]) cycles_o = TMR_W'(CYC_FAST);
    else                          cycles_o = TMR_W'(CYC_SLOW);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q  <= '0;
      src_q <= '0;
      log_q <= 1'b0;
      a24_q <= 1'b0;
    end else if (launch_i) begin
      ea_q  <= ea_c;
      src_q <= src_i;
      log_q <= &base_i[PTR_W-1 -: HI_W];
      a24_q <= addr24_i;
    end
  end

  assign a_k = ea_q + PTR_W'(byte_idx_i);

  always_comb begin
    if (log_q)      addr_o = {{HI_W{1'b0}}, a_k[LOG_W-1:0]};
    else if (a24_q) addr_o = a_k & WMASK;
    else            addr_o = a_k & NMASK;
  end

  assign data_o    = src_q[{byte_idx_i, 3'b000} +: 8];
  assign logical_o = log_q;
endmodule

// File: rtl/ptr_store_seq.sv
module ptr_store_seq
  import ptr_store_pkg::*;
#(
  parameter int NBYTE = 4,
  parameter int BI_W  = 2,
  parameter int TMR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [TMR_W-1:0] cycles_i,
  input  logic             ready_i,
  output logic             we_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [BI_W-1:0]  byte_idx_o
);
  localparam logic [BI_W-1:0]  LAST = BI_W'(NBYTE - 1);
  // two opcode cycles precede the first busy cycle, done lands on the last one
  localparam logic [TMR_W-1:0] PRE  = TMR_W'(3);

  seq_state_e       st_q;
  logic [TMR_W-1:0] tmr_q, tmr_dec;

  assign tmr_dec = (tmr_q == '0) ? '0 : tmr_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      byte_idx_o <= '0;
      tmr_q      <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (launch_i) begin
          st_q       <= SQ_WR;
          byte_idx_o <= '0;
          tmr_q      <= cycles_i - PRE;
        end
        SQ_WR: begin
          st_q  <= SQ_ACK;
          tmr_q <= tmr_dec;
        end
        SQ_ACK: begin
          tmr_q <= tmr_dec;
          if (ready_i) begin
            if (byte_idx_o == LAST) st_q <= SQ_HOLD;
            else begin
              byte_idx_o <= byte_idx_o + 1'b1;
              st_q       <= SQ_WR;
            end
          end
        end
        SQ_HOLD: begin
          if (tmr_q == '0) st_q <= SQ_IDLE;
          else             tmr_q <= tmr_dec;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign we_o   = (st_q == SQ_WR);
  assign busy_o = (st_q != SQ_IDLE);
  assign done_o = (st_q == SQ_HOLD) && (tmr_q == '0);
endmodule

// File: rtl/ptr_store_unit.sv
module ptr_store_unit #(
  parameter int         PTR_W    = 32,
  parameter int         IDX_W    = 16,
  parameter int         NPTR     = 4,
  parameter int         LOG_W    = 16,
  parameter int         PHYS_NW  = 20,
  parameter int         PHYS_WW  = 24,
  parameter logic [7:0] PREFIX   = 8'h6D,
  parameter logic [3:0] SUB_NIB  = 4'hB,
  parameter int         CYC_FIX  = 18,
  parameter int         CYC_SLOW = 19,
  parameter int         CYC_FAST = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rf_we_i,
  input  logic [2:0]       rf_sel_i,
  input  logic [PTR_W-1:0] rf_wdata_i,
  input  logic             op_valid_i,
  input  logic [7:0]       op_byte_i,
  output logic             op_ready_o,
  input  logic             cfg_tmode_i,
  input  logic             cfg_bus16_i,
  input  logic             cfg_addr24_i,
  output logic             mem_we_o,
  output logic [PTR_W-1:0] mem_addr_o,
  output logic [7:0]       mem_data_o,
  output logic             mem_xlat_o,
  input  logic             mem_ready_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam int SEL_W = $clog2(NPTR);
  localparam int NBYTE = PTR_W / 8;
  localparam int BI_W  = $clog2(NBYTE);
  localparam int TMR_W = $clog2(CYC_SLOW + 1);

  logic [NPTR-1:0][PTR_W-1:0] ptr;
  logic [IDX_W-1:0]           idx;
  logic [SEL_W-1:0]           src_sel, base_sel;
  logic                       launch, we, logical;
  logic [TMR_W-1:0]           cycles;
  logic [BI_W-1:0]            byte_idx;

  assign src_sel  = op_byte_i[7 -: SEL_W];
  assign base_sel = op_byte_i[5 -: SEL_W];

  ptr_store_regfile #(
    .PTR_W(PTR_W), .IDX_W(IDX_W), .NPTR(NPTR), .RS_W(3)
  ) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we_i), .sel_i(rf_sel_i), .wdata_i(rf_wdata_i),
    .ptr_o(ptr), .idx_o(idx)
  );

  ptr_store_decode #(.PREFIX(PREFIX), .SUB_NIB(SUB_NIB)) u_dec (
    .clk_i, .rst_ni,
    .valid_i(op_valid_i), .ready_i(op_ready_o), .byte_i(op_byte_i),
    .launch_o(launch)
  );

  ptr_store_agen #(
    .PTR_W(PTR_W), .IDX_W(IDX_W), .LOG_W(LOG_W), .PHYS_NW(PHYS_NW),
    .PHYS_WW(PHYS_WW), .BI_W(BI_W), .TMR_W(TMR_W),
    .CYC_FIX(CYC_FIX), .CYC_SLOW(CYC_SLOW), .CYC_FAST(CYC_FAST)
  ) u_agen (
    .clk_i, .rst_ni,
    .launch_i(launch), .base_i(ptr[base_sel]), .src_i(ptr[src_sel]),
    .idx_i(idx), .tmode_i(cfg_tmode_i), .bus16_i(cfg_bus16_i),
    .addr24_i(cfg_addr24_i), .byte_idx_i(byte_idx),
    .cycles_o(cycles), .addr_o(mem_addr_o), .data_o(mem_data_o),
    .logical_o(logical)
  );

  ptr_store_seq #(.NBYTE(NBYTE), .BI_W(BI_W), .TMR_W(TMR_W)) u_seq (
    .clk_i, .rst_ni,
    .launch_i(launch), .cycles_i(cycles), .ready_i(mem_ready_i),
    .we_o(we), .busy_o(busy_o), .done_o(done_o), .byte_idx_o(byte_idx)
  );

  assign op_ready_o = !busy_o;
  assign mem_we_o   = we;
  assign mem_xlat_o = we && logical;
endmodule

// File: rtl/ptr_store_unit_chk.sv
module ptr_store_unit_chk #(
  parameter int PTR_W   = 32,
  parameter int LOG_W   = 16,
  parameter int PHYS_WW = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_we_o,
  input logic [PTR_W-1:0] mem_addr_o,
  input logic             mem_xlat_o,
  input logic             busy_o,
  input logic             done_o
);
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R9
  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R9
  AST_WE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o && !done_o); // R9
  AST_XLAT_WITH_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_xlat_o |-> mem_we_o); // R5
  AST_LOGICAL_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_xlat_o) |-> (mem_addr_o[PTR_W-1:LOG_W] == '0)); // R5
  AST_PHYS_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_xlat_o) |-> (mem_addr_o[PTR_W-1:PHYS_WW] == '0)); // R6
endmodule

bind ptr_store_unit ptr_store_unit_chk #(
  .PTR_W(PTR_W), .LOG_W(LOG_W), .PHYS_WW(PHYS_WW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_xlat_o(mem_xlat_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/ptr_store_unit_test.sv
module ptr_store_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rf_we = 1'b0;
  logic [2:0]  rf_sel = '0;
  logic [31:0] rf_wdata = '0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = '0;
  logic        op_ready;
  logic        tmode = 1'b0, bus16 = 1'b0, addr24 = 1'b0;
  logic        mem_we, mem_xlat, busy, done;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data;
  logic        mem_ready = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] sh [4];

  always #5 clk = ~clk;

  ptr_store_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rf_we_i(rf_we), .rf_sel_i(rf_sel), .rf_wdata_i(rf_wdata),
    .op_valid_i(op_valid), .op_byte_i(op_byte), .op_ready_o(op_ready),
    .cfg_tmode_i(tmode), .cfg_bus16_i(bus16), .cfg_addr24_i(addr24),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_xlat_o(mem_xlat), .mem_ready_i(mem_ready),
    .busy_o(busy), .done_o(done)
  );

  // {op2[8], idx[16], tmode, bus16, addr24, stall}
  localparam logic [27:0] VEC [8] = '{
    {8'h0B, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h1B, 16'h0012, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'hEB, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h7B, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hAB, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h9B, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hDB, 16'h000E, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h4B, 16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rf_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_sel = sel; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  // returns in the cycle after the second byte was accepted (cycle 3)
  task automatic send_pair(input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk);
    op_valid = 1'b1; op_byte = b0;
    @(negedge clk);
    op_byte = b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic quiet(input string req, input int cyc);
    bit bad = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      if (mem_we || busy) bad = 1'b1;
      @(negedge clk);
    end
    chk(!bad, req, {30'd0, busy, mem_we}, 32'd0);
  endtask

  task automatic run_vec(input logic [7:0] op2, input logic [15:0] idx,
                         input bit tm, input bit b16, input bit a24, input bit stall);
    logic [31:0] src, base, ea, a, ea_addr;
    bit          lg;
    int          n, exp_done, done_at, nw, exp_cyc;
    rf_write(3'd4, {16'hBEEF, idx}); // R10: upper data bits ignored for index
    @(negedge clk);
    tmode = tm; bus16 = b16; addr24 = a24;
    src  = sh[op2[7:6]];
    base = sh[op2[5:4]];
    ea   = base + {16'd0, idx};
    lg   = (base[31:16] == 16'hFFFF);
    n    = !tm ? 18 : ((b16 && !ea[0]) ? 17 : 19);
    exp_done = stall ? 22 : n;
    send_pair(8'h6D, op2);
    nw = 0; done_at = 0;
    for (int k = 3; k < 40 && done_at == 0; k++) begin
      mem_ready = !(stall && k < 15);
      if (k == 3) chk(busy && !op_ready, "R9 busy after decode", {30'd0, busy, op_ready}, 32'd2);
      if (mem_we) begin
        if (nw < 4) begin
          a = ea + nw;
          ea_addr = lg ? (a & 32'h0000FFFF) : (a24 ? (a & 32'h00FFFFFF) : (a & 32'h000FFFFF));
          exp_cyc = (stall && nw > 0) ? 14 + 2 * nw : 3 + 2 * nw;
          chk(mem_addr == ea_addr, "R3/R5/R6 write address", mem_addr, ea_addr);
          chk(mem_data == src[8*nw +: 8], "R2/R4 write data byte", {24'd0, mem_data}, {24'd0, src[8*nw +: 8]});
          chk(mem_xlat == lg, "R5/R6 translate flag", {31'd0, mem_xlat}, {31'd0, lg});
          chk(k == exp_cyc, "R8 write strobe cycle", k, exp_cyc);
        end
        nw++;
      end
      if (done) done_at = k;
      @(negedge clk);
    end
    mem_ready = 1'b1;
    chk(nw == 4, "R4 write count", nw, 4);
    chk(done_at == exp_done, "R7 done cycle", done_at, exp_done);
    chk(!busy && op_ready && !done, "R9 idle after done", {29'd0, busy, op_ready, done}, 32'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog act=timeout exp=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(!mem_we && !busy && !done && op_ready, "R11 reset outputs",
        {28'd0, mem_we, busy, done, op_ready}, 32'd1);
    rst_n = 1'b1;
    sh[0] = 32'h0012_3450; sh[1] = 32'hFFFF_FFF0;
    sh[2] = 32'h00FF_FFFE; sh[3] = 32'hA5C3_0001;
    for (int i = 0; i < 4; i++) rf_write(3'(i), sh[i]);
    rf_write(3'd5, 32'hDEAD_BEEF); // R10: unused select codes
    rf_write(3'd7, 32'h1357_9BDF);

    // R1: near-miss opcodes
    send_pair(8'h6D, 8'h5C);
    quiet("R1 second byte mismatch", 12);
    send_pair(8'h00, 8'h0B);
    quiet("R1 missing prefix", 12);
    @(negedge clk);
    op_valid = 1'b1; op_byte = 8'h6D;
    @(negedge clk); op_byte = 8'h6D;
    @(negedge clk); op_byte = 8'h0B;
    @(negedge clk); op_valid = 1'b0;
    quiet("R1 prefix then prefix", 12);

    for (int v = 0; v < 8; v++)
      run_vec(VEC[v][27:20], VEC[v][19:4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);

    // R11: reset in the middle of a store
    send_pair(8'h6D, 8'hEB);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!mem_we && !busy && !done && op_ready, "R11 reset aborts store",
        {28'd0, mem_we, busy, done, op_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    quiet("R11 no resumed writes", 6);
    for (int i = 0; i < 4; i++) sh[i] = '0;
    run_vec(8'hFB, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0); // R11: registers cleared

    summary();
    $finish;
  end
endmodule